// File: doc/BRIEF.md
# I2S Audio Transmit Channel

This block turns 32-bit audio words, written by a host into an eight-entry transmit queue, into an I2S serial stream. A 16-bit control word sets the sample width, mono or stereo packing, the word-select role (generator or follower), and the word-select half period. It also carries a mute switch, a stop switch that freezes the queue, and a channel clear. Serial timing comes from a one-cycle `bitTick` strobe supplied by the surrounding logic. Each strobe stands for one falling edge of the bit clock, and every serial output change happens on such a strobe.

In generator mode the block toggles word-select after every half-period-plus-one bit ticks, starting with a left slot. In follower mode it samples `wsIn` on each tick and frames slots on its edges. Every slot starts with the sample's most significant bit, one tick after the word-select edge, and is padded with zeros beyond the sample width. An empty queue at a slot that needs a sample yields a zero slot and a sticky underrun flag.

Top module: `i2s_tx_channel`

## Requirements
- R1: The queue holds 8 words of 32 bits. `fifoLevel` counts stored words, `fifoFull` is high at 8, and a write while full leaves the level and the later stream unchanged.
- R2: Control word layout: [8:0] half period minus one, [10:9] width code, [11] mono, [12] follower role, [13] mute, [14] stop, [15] channel clear. The reset value is 0x321F: follower, muted, 16-bit, half period 31. After reset the level is 0, full and underrun are low, `sdOut` is 0, and `wsOut` tracks `wsIn` on ticks.
- R3: Width code 0 sends bits [7:0] of the word, code 1 sends [15:0], and codes 3 and 2 (reserved) send all 32 bits. The sample is sent MSB first, and slot bits past the sample width are 0.
- R4: The first bit of a slot (the sample MSB) appears on the tick after the tick that changes word-select. The tick that changes word-select carries the last bit of the previous slot.
- R5: In generator mode `wsOut` changes only on ticks, once every half period + 1 ticks. The first change after a channel clear goes low, which marks a left slot.
- R6: In follower mode `wsOut` equals `wsIn` as sampled on the latest tick, and slots are framed by those edges.
- R7: In stereo mode (mono bit 0) consecutive queue words fill alternate slots, left first. In mono mode each word fills a left slot and the following right slot.
- R8: With mute set, `sdOut` stays 0, framing continues, and queue words are still consumed.
- R9: With stop set, `sdOut` stays 0, writes are ignored, no word is consumed, and no underrun is flagged.
- R10: Setting the channel clear bit empties the queue and clears the underrun flag at once. While the bit is held, writes are ignored.
- R11: When a slot needs a word and the queue is empty (stop clear), the slot is all zeros and `underrun` goes high. It stays high until a channel clear.

Underrun and zero-fill are checked on the stream in R11; the first-slot direction of R5 is checked by the stream sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 16 | Control word value |
| wrEn | input | 1 | Queue write strobe |
| wrData | input | 32 | Queue write word |
| bitTick | input | 1 | One-cycle strobe, one per bit clock falling edge |
| wsIn | input | 1 | External word-select, used in follower mode |
| fifoLevel | output | 4 | Number of queued words |
| fifoFull | output | 1 | Queue holds 8 words |
| underrun | output | 1 | Sticky empty-queue-at-slot flag |
| wsOut | output | 1 | Word-select, low for the left slot |
| sdOut | output | 1 | Serial data |

## Verification
A queue write shows up in `fifoLevel` at the sample point after the clock that took it, and a channel clear shows up at the same point after the control write. Serial results pass through one register, so `wsOut` and `sdOut` reflect a tick at the clock edge that sees it. The bench raises `bitTick` for a single clock and reads both outputs at the following falling edge, which gives one sample per tick. It then splits the recorded stream at word-select changes and compares the bits from the tick after each change onward against slot words it builds from the width, packing and written data.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int CTRL_W    = 16;
  localparam int HALF_W    = 9;
  localparam int WIDTH_LSB = 9;
  localparam int MONO_BIT  = 11;
  localparam int SLAVE_BIT = 12;
  localparam int MUTE_BIT  = 13;
  localparam int STOP_BIT  = 14;
  localparam int CLR_BIT   = 15;

  localparam logic [1:0] WIDTH_8  = 2'd0;
  localparam logic [1:0] WIDTH_16 = 2'd1;

  localparam logic [CTRL_W-1:0] CTRL_RESET =
    CTRL_W'((1 << MUTE_BIT) | (1 << SLAVE_BIT) | (int'(WIDTH_16) << WIDTH_LSB) | 31);

  typedef struct packed {
    logic shift;     // bit tick: advance serial register
    logic load;      // slot start: load a new slot word
    logic pop;       // take the head word from the queue
    logic useHold;   // reuse the word held for the mono pair
    logic zeroFill;  // slot gets zeros (empty queue or stopped)
    logic lockFifo;  // no queue writes accepted
    logic muteOut;   // force serial output low
  } txStrobe_t;
endpackage

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              bitTick,
  input  logic              wsIn,
  input  logic              fifoEmpty,
  output logic              chanRunN,
  output logic              wsOut,
  output logic              underrun,
  output logic [1:0]        widthSel,
  output txStrobe_t         strobe
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [HALF_W-1:0] halfPeriod, halfCnt, cntNext;
  logic monoMode, slaveMode, muteBit, stopBit, clrBit;
  logic wsQ, wsNext, atLimit, slotEdge, needSample, starve, underQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlQ <= CTRL_RESET;
    else if (ctrlWe) ctrlQ <= ctrlWdata;
  end

  assign halfPeriod = ctrlQ[HALF_W-1:0];
  assign widthSel   = ctrlQ[WIDTH_LSB +: 2];
  assign monoMode   = ctrlQ[MONO_BIT];
  assign slaveMode  = ctrlQ[SLAVE_BIT];
  assign muteBit    = ctrlQ[MUTE_BIT];
  assign stopBit    = ctrlQ[STOP_BIT];
  assign clrBit     = ctrlQ[CLR_BIT];

  assign chanRunN = rstN & ~clrBit;

  always_comb begin
    atLimit = (halfCnt >= halfPeriod);
    if (slaveMode) begin
      wsNext  = wsIn;
      cntNext = '0;
    end else begin
      wsNext  = atLimit ? ~wsQ : wsQ;
      cntNext = atLimit ? '0 : halfCnt + 1'b1;
    end
  end

  // A left slot is entered when word-select goes low.
  assign slotEdge   = bitTick && (wsNext != wsQ);
  assign needSample = slotEdge && !(monoMode && wsNext);
  assign starve     = needSample && fifoEmpty;

  always_comb begin
    strobe.shift    = bitTick;
    strobe.load     = slotEdge;
    strobe.pop      = needSample && !stopBit && !fifoEmpty;
    strobe.zeroFill = needSample && (stopBit || fifoEmpty);
    strobe.useHold  = slotEdge && monoMode && wsNext;
    strobe.lockFifo = stopBit;
    strobe.muteOut  = muteBit || stopBit;
  end

  always_ff @(posedge clk or negedge chanRunN) begin
    if (!chanRunN) begin
      wsQ     <= 1'b1;
      halfCnt <= '0;
      underQ  <= 1'b0;
    end else begin
      if (bitTick) begin
        wsQ     <= wsNext;
        halfCnt <= cntNext;
      end
      if (starve && !stopBit) underQ <= 1'b1;
    end
  end

  assign wsOut    = wsQ;
  assign underrun = underQ;
endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              chanRunN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  input  logic [1:0]        widthSel,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              sdOut
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  count;
  logic [DATA_W-1:0] srcWord, alignedWord, shReg, holdQ;
  logic              push, sdBit;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoFull  = (count == LVL_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign fifoLevel = count;
  assign push      = wrEn && !fifoFull && !strobe.lockFifo;

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge chanRunN) begin
    if (!chanRunN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)       wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) rdPtr <= nextPtr(rdPtr);
      case ({push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    if (strobe.useHold)       srcWord = holdQ;
    else if (strobe.zeroFill) srcWord = '0;
    else                      srcWord = mem[rdPtr];
    case (widthSel)
      WIDTH_8:  alignedWord = {srcWord[7:0],  {(DATA_W - 8){1'b0}}};
      WIDTH_16: alignedWord = {srcWord[15:0], {(DATA_W - 16){1'b0}}};
      default:  alignedWord = srcWord;
    endcase
  end

  always_ff @(posedge clk or negedge chanRunN) begin
    if (!chanRunN) begin
      shReg <= '0;
      sdBit <= 1'b0;
      holdQ <= '0;
    end else if (strobe.shift) begin
      sdBit <= shReg[DATA_W-1];
      if (strobe.load) begin
        shReg <= alignedWord;
        if (!strobe.useHold) holdQ <= srcWord;
      end else begin
        shReg <= shReg << 1;
      end
    end
  end

  assign sdOut = sdBit & ~strobe.muteOut;
endmodule

// File: rtl/i2s_tx_channel.sv
module i2s_tx_channel
  import i2s_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int WORD_W     = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              bitTick,
  input  logic              wsIn,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoFull,
  output logic              underrun,
  output logic              wsOut,
  output logic              sdOut
);
  txStrobe_t  txStb;
  logic       chanRunN;
  logic       fifoEmpty;
  logic [1:0] widthSel;

  i2s_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .bitTick(bitTick), .wsIn(wsIn), .fifoEmpty(fifoEmpty),
    .chanRunN(chanRunN), .wsOut(wsOut), .underrun(underrun),
    .widthSel(widthSel), .strobe(txStb)
  );

  i2s_tx_datapath #(.DEPTH(FIFO_DEPTH), .DATA_W(WORD_W)) u_data (
    .clk(clk), .chanRunN(chanRunN), .wrEn(wrEn), .wrData(wrData),
    .strobe(txStb), .widthSel(widthSel), .fifoLevel(fifoLevel),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .sdOut(sdOut)
  );
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             chanRunN,
  input logic             bitTick,
  input logic             ctrlWe,
  input logic             stopActive,
  input logic [LVL_W-1:0] fifoLevel,
  input logic             underrun,
  input logic             wsOut,
  input logic             sdOut
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!chanRunN)
    fifoLevel <= LVL_W'(DEPTH));

  p_level_step_r1: assert property (@(posedge clk) disable iff (!chanRunN)
    (fifoLevel == $past(fifoLevel)) || (fifoLevel == $past(fifoLevel) + 1'b1) ||
    (fifoLevel + 1'b1 == $past(fifoLevel)));

  p_sd_on_tick_r4: assert property (@(posedge clk) disable iff (!chanRunN)
    (!bitTick && !ctrlWe) |=> $stable(sdOut));

  p_ws_on_tick_r5: assert property (@(posedge clk) disable iff (!chanRunN)
    !bitTick |=> $stable(wsOut));

  p_stop_frozen_r9: assert property (@(posedge clk) disable iff (!chanRunN)
    (stopActive && $past(stopActive)) |-> $stable(fifoLevel));

  p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    !chanRunN |-> (fifoLevel == '0) && !underrun);

  p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (!chanRunN)
    underrun |=> underrun);
endmodule

bind i2s_tx_channel i2s_tx_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanRunN(chanRunN), .bitTick(bitTick),
  .ctrlWe(ctrlWe), .stopActive(txStb.lockFifo), .fifoLevel(fifoLevel),
  .underrun(underrun), .wsOut(wsOut), .sdOut(sdOut)
);

// File: tb/tb_i2s_tx_channel.sv
module tb_i2s_tx_channel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [15:0] ctrlWdata = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        bitTick = 1'b0;
  logic        wsIn = 1'b1;
  logic [3:0]  fifoLevel;
  logic        fifoFull, underrun, wsOut, sdOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit recWs [0:2047];
  bit recSd [0:2047];
  bit recWsIn [0:2047];
  int recN = 0;
  int slvCnt = 0;
  int slvLen = 20;
  logic [31:0] samp [0:8];

  always #10 clk = ~clk;

  i2s_tx_channel dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .wrEn(wrEn), .wrData(wrData), .bitTick(bitTick), .wsIn(wsIn),
    .fifoLevel(fifoLevel), .fifoFull(fifoFull), .underrun(underrun),
    .wsOut(wsOut), .sdOut(sdOut)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCtrl(input int half, input int width, input bit mono,
                                         input bit slave, input bit mute, input bit stop,
                                         input bit clr);
    return {clr, stop, mute, slave, mono, width[1:0], half[8:0]};
  endfunction

  task automatic wrCtrl(input logic [15:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk); wrEn = 1'b1; wrData = w;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n, input bit drive);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      bitTick = 1'b1;
      if (drive) begin
        slvCnt++;
        if (slvCnt == slvLen) begin wsIn = ~wsIn; slvCnt = 0; end
      end
      @(negedge clk);
      bitTick = 1'b0;
      if (recN < 2048) begin
        recWs[recN] = wsOut; recSd[recN] = sdOut; recWsIn[recN] = wsIn; recN++;
      end
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] slotBits(input logic [31:0] w, input int width, input int len);
    logic [31:0] a;
    logic [63:0] r = '0;
    case (width)
      0: a = {w[7:0], 24'b0};
      1: a = {w[15:0], 16'b0};
      default: a = w;
    endcase
    for (int k = 1; k <= len; k++) r = {r[62:0], (k <= 32) ? a[32-k] : 1'b0};
    return r;
  endfunction

  task automatic runStream(input int runId, input int half, input int width, input bit mono,
                           input bit slave, input int ls);
    int len, nFrames, prevEdge, slot;
    logic [31:0] expWord;
    logic [63:0] got, exp;
    len = slave ? ls : half + 1;
    nFrames = mono ? 10 : 6;
    wsIn = 1'b1; slvCnt = 0; slvLen = ls;
    wrCtrl(mkCtrl(half, width, mono, slave, 1'b0, 1'b0, 1'b1));
    check(fifoLevel == 0, "R10 clear level", fifoLevel, 0);
    wrCtrl(mkCtrl(half, width, mono, slave, 1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 9; k++) begin
      samp[k] = (32'h9E3779B9 * (k + 1)) ^ (32'h01010101 * runId);
      pushWord(samp[k]);
      if (k == 7) check(fifoFull == 1'b1, "R1 full at 8", fifoFull, 1);
    end
    check(fifoLevel == 8, "R1 write while full ignored", fifoLevel, 8);
    check(underrun == 1'b0, "R11 no underrun before slots", underrun, 0);
    recN = 0;
    runTicks(len * (2 * nFrames + 2), slave);
    prevEdge = -1; slot = 0;
    for (int i = 1; i < recN; i++) begin
      if (recWs[i] != recWs[i-1]) begin
        if (slot == 0) check(recWs[i] == 1'b0, "R5 first slot is left", recWs[i], 0);
        else check((i - prevEdge) == len, slave ? "R6 slot length" : "R5 slot length",
                   i - prevEdge, len);
        if (i + len < recN) begin
          if (mono) expWord = (slot / 2 < 8) ? samp[slot / 2] : 32'h0;
          else      expWord = (slot < 8) ? samp[slot] : 32'h0;
          exp = slotBits(expWord, width, len);
          got = '0;
          for (int k = 1; k <= len; k++) got = {got[62:0], recSd[i + k]};
          check(got == exp, "R3 R4 R7 R11 slot bits", got, exp);
        end
        prevEdge = i; slot++;
      end
    end
    check(slot >= 2 * nFrames, "R5 R6 slot count", slot, 2 * nFrames);
    if (slave) begin
      int bad = 0;
      for (int i = 0; i < recN; i++) if (recWs[i] != recWsIn[i]) bad++;
      check(bad == 0, "R6 ws follows input", bad, 0);
    end
    check(underrun == 1'b1, "R11 underrun flagged", underrun, 1);
    check(fifoLevel == 0, "R7 queue drained", fifoLevel, 0);
  endtask

  initial begin
    int edges, ones;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(fifoLevel == 0, "R2 reset level", fifoLevel, 0);
    check(fifoFull == 0, "R2 reset full", fifoFull, 0);
    check(underrun == 0, "R2 reset underrun", underrun, 0);
    check(sdOut == 0, "R2 reset sdOut", sdOut, 0);
    for (int k = 0; k < 4; k++) pushWord(32'hFFFF_FFFF);
    recN = 0; slvCnt = 0; slvLen = 10;
    runTicks(100, 1'b1);
    ones = 0; edges = 0;
    for (int i = 0; i < recN; i++) begin
      if (recSd[i]) ones++;
      if (recWs[i] != recWsIn[i]) edges++;
    end
    check(ones == 0, "R2 muted by default", ones, 0);
    check(edges == 0, "R2 follower by default", edges, 0);

    for (int w = 0; w < 4; w++)
      for (int m = 0; m < 2; m++)
        for (int h = 0; h < 2; h++)
          runStream(w * 4 + m * 2 + h, h ? 31 : 15, w, m[0], 1'b0, 0);
    runStream(20, 39, 3, 1'b0, 1'b0, 0);
    runStream(21, 31, 1, 1'b0, 1'b1, 20);
    runStream(22, 31, 0, 1'b1, 1'b1, 12);

    // R8 mute: zeros, framing continues, words consumed
    wrCtrl(mkCtrl(7, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
    wrCtrl(mkCtrl(7, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    for (int k = 0; k < 4; k++) pushWord(32'hFFFF_FFFF);
    recN = 0;
    runTicks(96, 1'b0);
    ones = 0; edges = 0;
    for (int i = 1; i < recN; i++) begin
      if (recSd[i]) ones++;
      if (recWs[i] != recWs[i-1]) edges++;
    end
    check(ones == 0, "R8 muted output", ones, 0);
    check(edges >= 10, "R8 framing continues", edges, 10);
    check(fifoLevel == 0, "R8 words consumed", fifoLevel, 0);
    check(underrun == 1, "R11 underrun while muted", underrun, 1);

    // R10 channel clear
    pushWord(32'h1234_5678);
    wrCtrl(mkCtrl(7, 1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
    check(fifoLevel == 0, "R10 level cleared", fifoLevel, 0);
    check(underrun == 0, "R10 underrun cleared", underrun, 0);
    pushWord(32'h1234_5678);
    check(fifoLevel == 0, "R10 write ignored while clear", fifoLevel, 0);

    // R9 stop
    wrCtrl(mkCtrl(7, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 3; k++) pushWord(32'hFFFF_FFFF);
    wrCtrl(mkCtrl(7, 1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    pushWord(32'hFFFF_FFFF);
    check(fifoLevel == 3, "R9 write ignored", fifoLevel, 3);
    recN = 0;
    runTicks(80, 1'b0);
    ones = 0; edges = 0;
    for (int i = 1; i < recN; i++) begin
      if (recSd[i]) ones++;
      if (recWs[i] != recWs[i-1]) edges++;
    end
    check(ones == 0, "R9 stopped output", ones, 0);
    check(edges >= 8, "R9 framing continues", edges, 8);
    check(fifoLevel == 3, "R9 no word consumed", fifoLevel, 3);
    check(underrun == 0, "R9 no underrun", underrun, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule